// File: doc/BRIEF.md
# Charge time measurement edge controller

This block is the digital control core of a capacitive charge-timing peripheral. Two external edge pins and a comparator level are brought into the clock domain. Two status channels watch the pins. Each channel has its own pin route and its own edge polarity. A selected edge sets that channel's sticky flag. The analog current source charges a capacitor only while exactly one of the two flags is set. The time between the start edge and the stop edge therefore sets the charge. When charging ends, the block can fire a single-cycle trigger so that an ADC samples the capacitor voltage.

Software drives the block through a small register port with four 8-bit locations: control, routing, status and current. The status flags can be read and rewritten at any time. The block also turns the current register into a one-hot range select and a signed trim value. A discharge control grounds the measured node and takes priority over charging. A timing-pulse output tracks the charging window, and an optional comparator path can close that window.

Top module: `ctm_edge_ctrl`

## Requirements
- R1: While control bit 0 (enable) is 0, `src_en`, `pulse_out`, `adc_trig` and `discharge` stay 0 and pin edges do not set any flag.
- R2: While control bit 1 (edge gate) is 0, pin edges do not change the flags. The pin levels are still tracked, so setting the gate again while a pin is held high produces no flag.
- R3: Each channel's 2-bit route field selects its pin: 11 picks `pin_a`, 10 picks `pin_b`, and 00 or 01 picks no pin. The routing register holds channel 1 in bits [2:0] and channel 2 in bits [5:3]. Within each 3-bit group, the route is in the low two bits and the polarity is in the top bit.
- R4: If a channel's polarity bit is 1, a rising edge on its pin sets its flag. If the bit is 0, a falling edge sets it.
- R5: The flags are sticky and edges only set them. Flag 1 is status bit 0 and flag 2 is status bit 1. A write to the status register loads both flags from wdata[1:0].
- R6: `src_en` is 1 exactly when enable is 1, discharge is 0, and exactly one flag is set. It follows the flags one cycle later.
- R7: While enable and control bit 2 (pulse generation) are both 1, `pulse_out` is 1 exactly when exactly one flag is set. Otherwise it is 0.
- R8: With enable and control bit 3 (trigger enable) set, each change of the one-flag condition from true to false produces a single-cycle `adc_trig` pulse. No pulse is produced when trigger enable is 0.
- R9: While enable and control bit 4 (discharge) are 1, `discharge` is 1 and `src_en` is 0. When the discharge bit is cleared, `src_en` again follows the flags.
- R10: While enable and pulse generation are set, a high level on `cmp_in` sets flag 2. Otherwise `cmp_in` has no effect.
- R11: Current register bits [1:0] decode to `range_sel` as 00 to 000, 01 to 001, 10 to 010 and 11 to 100. `trim` carries register bits [7:2] as a two's-complement value. Both outputs take effect two cycles after the write.
- R12: Address 0 is control (bits [4:0]), 1 is routing (bits [5:0]), 2 is status (bits [1:0]) and 3 is current (bits [7:0]). Unimplemented bits read 0. `rdata` shows the location at `addr` one cycle later. All registers and outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_a | input | 1 | Asynchronous edge pin A |
| pin_b | input | 1 | Asynchronous edge pin B |
| cmp_in | input | 1 | Asynchronous comparator level |
| src_en | output | 1 | Current-source enable |
| discharge | output | 1 | Ground the measured node |
| pulse_out | output | 1 | Timing pulse output |
| adc_trig | output | 1 | Single-cycle conversion trigger |
| range_sel | output | 3 | One-hot current range (base, x10, x100) |
| trim | output | 6 | Signed current trim |

## Verification
A flag that is stuck, set by the wrong pin, or set by the wrong polarity shows up at `src_en` within four cycles of the pin change. It also appears in the status readback one cycle after the address is presented. A lost or extra edge tracks wrongly on two outputs at once: the charging window is inverted, and `adc_trig` fires at the wrong point or not at all. A stale previous-charging register shows up as a missing trigger pulse or a trigger lasting two cycles. The bench catches both by counting pulses across each test window.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_ROUTE = 2'd1,
    A_STAT  = 2'd2,
    A_CUR   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic discharge;
    logic trig_en;
    logic pulse_en;
    logic edge_en;
    logic enable;
  } ctrl_t;

  typedef struct packed {
    logic       pol;
    logic [1:0] sel;
  } chan_cfg_t;

  localparam logic [1:0] SEL_PIN_A = 2'b11;
  localparam logic [1:0] SEL_PIN_B = 2'b10;
endpackage

// File: rtl/ctm_sync.sv
module ctm_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/ctm_edge_det.sv
module ctm_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] last_q;

  // Levels are tracked regardless of any gate so that re-enabling is clean.
  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else     last_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~last_q;
  assign fall_o = ~lvl_i & last_q;
endmodule

// File: rtl/ctm_status.sv
module ctm_status
  import ctm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 gate_i,
  input  logic [1:0]           rise_i,
  input  logic [1:0]           fall_i,
  input  chan_cfg_t [NCH-1:0]  cfg_i,
  input  logic                 cmp_set_i,
  input  logic                 wr_i,
  input  logic [NCH-1:0]       wdata_i,
  output logic [NCH-1:0]       flags_o
);
  logic [NCH-1:0] set_v;
  logic [NCH-1:0] cmp_v;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit_r, hit_f;
    always_comb begin
      hit_r = 1'b0;
      hit_f = 1'b0;
      if (cfg_i[c].sel == SEL_PIN_A) begin
        hit_r = rise_i[0];
        hit_f = fall_i[0];
      end else if (cfg_i[c].sel == SEL_PIN_B) begin
        hit_r = rise_i[1];
        hit_f = fall_i[1];
      end
    end
    assign set_v[c] = gate_i & (cfg_i[c].pol ? hit_r : hit_f);

    // R5: a set flag survives until software rewrites it
    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      (flags_o[c] && !wr_i) |=> flags_o[c]);
  end

  assign cmp_v = {cmp_set_i, {(NCH-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) flags_o <= '0;
    else     flags_o <= (wr_i ? wdata_i : flags_o) | set_v | cmp_v;
  end

  // R2: with no gate, no comparator and no write the flags hold
  p_edge_blocked_r2: assert property (@(posedge clk) disable iff (rst)
    (!gate_i && !cmp_set_i && !wr_i) |=> (flags_o == $past(flags_o)));
endmodule

// File: rtl/ctm_outs.sv
module ctm_outs
  import ctm_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  ctrl_t          ctrl_i,
  input  logic [NCH-1:0] flags_i,
  output logic           src_en_o,
  output logic           dis_o,
  output logic           pulse_o,
  output logic           trig_o
);
  logic charging;
  logic chg_q;

  assign charging = flags_i[0] ^ flags_i[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      src_en_o <= 1'b0;
      dis_o    <= 1'b0;
      pulse_o  <= 1'b0;
      trig_o   <= 1'b0;
      chg_q    <= 1'b0;
    end else begin
      dis_o    <= ctrl_i.enable & ctrl_i.discharge;
      src_en_o <= ctrl_i.enable & ~ctrl_i.discharge & charging;
      pulse_o  <= ctrl_i.enable & ctrl_i.pulse_en & charging;
      chg_q    <= charging;
      trig_o   <= ctrl_i.enable & ctrl_i.trig_en & chg_q & ~charging;
    end
  end

  p_off_when_disabled_r1: assert property (@(posedge clk) disable iff (rst)
    !ctrl_i.enable |=> (!src_en_o && !pulse_o && !trig_o && !dis_o));

  p_src_xor_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_i.enable && !ctrl_i.discharge) |=>
      (src_en_o == ($past(flags_i[0]) ^ $past(flags_i[1]))));

  p_trig_single_r8: assert property (@(posedge clk) disable iff (rst)
    trig_o |=> !trig_o);

  p_discharge_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_i.enable && ctrl_i.discharge) |=> (dis_o && !src_en_o));
endmodule

// File: rtl/ctm_regs.sv
module ctm_regs
  import ctm_pkg::*;
#(
  parameter int DW = 8,
  localparam int TW = DW - 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_i,
  input  logic [1:0]          addr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [NCH-1:0]      flags_i,
  output ctrl_t               ctrl_o,
  output chan_cfg_t [NCH-1:0] cfg_o,
  output logic                stat_wr_o,
  output logic [NCH-1:0]      stat_wdata_o,
  output logic [DW-1:0]       rdata_o,
  output logic [2:0]          range_oh_o,
  output logic [TW-1:0]       trim_o
);
  localparam int CW = $bits(ctrl_t);
  localparam int RW = NCH * $bits(chan_cfg_t);

  ctrl_t         ctrl_q;
  logic [RW-1:0] route_q;
  logic [DW-1:0] cur_q;
  logic [DW-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      route_q <= '0;
      cur_q   <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_CTRL:  ctrl_q  <= ctrl_t'(wdata_i[CW-1:0]);
        A_ROUTE: route_q <= wdata_i[RW-1:0];
        A_CUR:   cur_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr_i)
      A_CTRL:  rd_next[CW-1:0]  = ctrl_q;
      A_ROUTE: rd_next[RW-1:0]  = route_q;
      A_STAT:  rd_next[NCH-1:0] = flags_i;
      default: rd_next          = cur_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o    <= '0;
      range_oh_o <= '0;
      trim_o     <= '0;
    end else begin
      rdata_o <= rd_next;
      trim_o  <= cur_q[DW-1:2];
      case (cur_q[1:0])
        2'b01:   range_oh_o <= 3'b001;
        2'b10:   range_oh_o <= 3'b010;
        2'b11:   range_oh_o <= 3'b100;
        default: range_oh_o <= 3'b000;
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_cfg
    assign cfg_o[c] = chan_cfg_t'(route_q[3*c +: 3]);
  end

  assign ctrl_o       = ctrl_q;
  assign stat_wr_o    = wr_i && (addr_i == A_STAT);
  assign stat_wdata_o = wdata_i[NCH-1:0];

  p_range_off_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == A_CUR && wdata_i[1:0] == 2'b00) |=> ##1 (range_oh_o == 3'b000));

  p_range_top_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == A_CUR && wdata_i[1:0] == 2'b11) |=> ##1 (range_oh_o == 3'b100));
endmodule

// File: rtl/ctm_edge_ctrl.sv
module ctm_edge_ctrl
  import ctm_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  localparam int TW = DW - 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          pin_a,
  input  logic          pin_b,
  input  logic          cmp_in,
  output logic          src_en,
  output logic          discharge,
  output logic          pulse_out,
  output logic          adc_trig,
  output logic [2:0]    range_sel,
  output logic [TW-1:0] trim
);
  logic [2:0]          lvl;
  logic [1:0]          rise, fall;
  ctrl_t               ctrl;
  chan_cfg_t [NCH-1:0] cfg;
  logic                stat_wr;
  logic [NCH-1:0]      stat_wdata;
  logic [NCH-1:0]      flags;
  logic                gate;
  logic                cmp_set;

  ctm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i({cmp_in, pin_b, pin_a}), .q_o(lvl)
  );

  ctm_edge_det #(.W(2)) u_edge (
    .clk(clk), .rst(rst), .lvl_i(lvl[1:0]), .rise_o(rise), .fall_o(fall)
  );

  ctm_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .flags_i(flags), .ctrl_o(ctrl), .cfg_o(cfg), .stat_wr_o(stat_wr),
    .stat_wdata_o(stat_wdata), .rdata_o(rdata), .range_oh_o(range_sel),
    .trim_o(trim)
  );

  assign gate    = ctrl.enable & ctrl.edge_en;
  assign cmp_set = ctrl.enable & ctrl.pulse_en & lvl[2];

  ctm_status u_stat (
    .clk(clk), .rst(rst), .gate_i(gate), .rise_i(rise), .fall_i(fall),
    .cfg_i(cfg), .cmp_set_i(cmp_set), .wr_i(stat_wr), .wdata_i(stat_wdata),
    .flags_o(flags)
  );

  ctm_outs u_outs (
    .clk(clk), .rst(rst), .ctrl_i(ctrl), .flags_i(flags),
    .src_en_o(src_en), .dis_o(discharge), .pulse_o(pulse_out), .trig_o(adc_trig)
  );
endmodule

// File: tb/sim_ctm_edge_ctrl.sv
`timescale 1ns/1ps
module sim_ctm_edge_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       pin_a = 1'b0, pin_b = 1'b0, cmp_in = 1'b0;
  logic       src_en, discharge, pulse_out, adc_trig;
  logic [2:0] range_sel;
  logic [5:0] trim;

  int n_chk = 0;
  int n_err = 0;
  int trig_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ctm_edge_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_a(pin_a), .pin_b(pin_b), .cmp_in(cmp_in),
    .src_en(src_en), .discharge(discharge), .pulse_out(pulse_out),
    .adc_trig(adc_trig), .range_sel(range_sel), .trim(trim)
  );

  always @(negedge clk) if (adc_trig) trig_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R12 reset src_en", src_en, 0);
    chk("R12 reset discharge", discharge, 0);
    chk("R12 reset pulse", pulse_out, 0);
    chk("R12 reset trig", adc_trig, 0);
    chk("R12 reset range", range_sel, 0);
    rd(2'd2, d); chk("R12 reset status", d, 0);
    rd(2'd0, d); chk("R12 reset ctrl", d, 0);
  endtask

  task automatic t_rising();
    logic [7:0] d;
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h37);
    pin_a = 1'b1; cyc(6);
    rd(2'd2, d); chk("R4 rising sets flag1 (R3 route 11)", d, 1);
    chk("R6 one flag charges", src_en, 1);
    pin_b = 1'b1; cyc(6);
    rd(2'd2, d); chk("R3 route 10 sets flag2", d, 3);
    chk("R6 both flags stop", src_en, 0);
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    wr(2'd2, 8'h00); cyc(3);
    rd(2'd2, d); chk("R5 write clears", d, 0);
    chk("R5 src after clear", src_en, 0);
    wr(2'd2, 8'h01); cyc(10);
    rd(2'd2, d); chk("R5 flag stays set", d, 1);
    wr(2'd2, 8'h00); cyc(2);
  endtask

  task automatic t_falling();
    logic [7:0] d;
    wr(2'd1, 8'h03);
    pin_b = 1'b0; cyc(6);
    rd(2'd2, d); chk("R3 route 00 ignores pin", d, 0);
    pin_a = 1'b0; cyc(6);
    rd(2'd2, d); chk("R4 falling sets flag1", d, 1);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h28);
    pin_b = 1'b1; cyc(6);
    rd(2'd2, d); chk("R3 route 01 ignores pin", d, 0);
    pin_b = 1'b0; cyc(6);
    wr(2'd1, 8'h18);
    pin_a = 1'b1; cyc(6);
    rd(2'd2, d); chk("R4 rising ignored with pol 0", d, 0);
    pin_a = 1'b0; cyc(6);
    rd(2'd2, d); chk("R3 flag2 routed to pin A", d, 2);
    wr(2'd2, 8'h00); cyc(2);
  endtask

  task automatic t_gate();
    logic [7:0] d;
    wr(2'd1, 8'h37);
    wr(2'd0, 8'h01);
    pin_a = 1'b1; cyc(6);
    rd(2'd2, d); chk("R2 gated edge ignored", d, 0);
    wr(2'd0, 8'h03); cyc(6);
    rd(2'd2, d); chk("R2 no spurious edge on re-enable", d, 0);
    pin_b = 1'b1; cyc(6);
    rd(2'd2, d); chk("R2 edges work after re-enable", d, 2);
    wr(2'd2, 8'h00); cyc(2);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    int c0;
    wr(2'd0, 8'h1E);
    pin_b = 1'b0; pin_a = 1'b0; cyc(6);
    pin_a = 1'b1; cyc(6);
    rd(2'd2, d); chk("R1 edges ignored when disabled", d, 0);
    c0 = trig_cnt;
    wr(2'd2, 8'h01); cyc(3);
    chk("R1 src off when disabled", src_en, 0);
    chk("R1 pulse off when disabled", pulse_out, 0);
    chk("R1 discharge off when disabled", discharge, 0);
    wr(2'd2, 8'h00); cyc(4);
    chk("R1 no trigger when disabled", trig_cnt - c0, 0);
    pin_a = 1'b0; cyc(6);
  endtask

  task automatic t_pulse_trig();
    int c0;
    wr(2'd0, 8'h0F);
    wr(2'd2, 8'h01); cyc(3);
    chk("R7 pulse high while charging", pulse_out, 1);
    chk("R6 src high while charging", src_en, 1);
    c0 = trig_cnt;
    wr(2'd2, 8'h03); cyc(4);
    chk("R7 pulse low after stop", pulse_out, 0);
    chk("R8 exactly one trigger", trig_cnt - c0, 1);
    wr(2'd2, 8'h00); cyc(4);
    chk("R8 no trigger without falling window", trig_cnt - c0, 1);
    wr(2'd0, 8'h07);
    c0 = trig_cnt;
    wr(2'd2, 8'h02); cyc(3);
    chk("R7 pulse on flag2 only", pulse_out, 1);
    wr(2'd2, 8'h00); cyc(4);
    chk("R8 trigger disabled", trig_cnt - c0, 0);
    wr(2'd0, 8'h03);
    wr(2'd2, 8'h01); cyc(3);
    chk("R7 pulse off without pulse gen", pulse_out, 0);
    wr(2'd2, 8'h00); cyc(2);
  endtask

  task automatic t_discharge();
    wr(2'd0, 8'h11);
    wr(2'd2, 8'h01); cyc(3);
    chk("R9 discharge asserted", discharge, 1);
    chk("R9 src blocked by discharge", src_en, 0);
    wr(2'd0, 8'h01); cyc(3);
    chk("R9 discharge released", discharge, 0);
    chk("R9 src restored from flags", src_en, 1);
    wr(2'd0, 8'h10); cyc(3);
    chk("R1 discharge needs enable", discharge, 0);
    wr(2'd2, 8'h00); cyc(2);
  endtask

  task automatic t_cmp();
    logic [7:0] d;
    wr(2'd0, 8'h05);
    cmp_in = 1'b1; cyc(6);
    rd(2'd2, d); chk("R10 comparator sets flag2", d, 2);
    cmp_in = 1'b0; cyc(4);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h01);
    cmp_in = 1'b1; cyc(6);
    rd(2'd2, d); chk("R10 comparator ignored without pulse gen", d, 0);
    cmp_in = 1'b0; cyc(4);
  endtask

  task automatic t_current();
    logic [7:0] d;
    wr(2'd3, 8'hFE); cyc(2);
    chk("R11 range x10", range_sel, 3'b010);
    chk("R11 trim -1", trim, 6'h3F);
    rd(2'd3, d); chk("R12 current readback", d, 8'hFE);
    wr(2'd3, 8'h05); cyc(2);
    chk("R11 range base", range_sel, 3'b001);
    chk("R11 trim +1", trim, 6'h01);
    wr(2'd3, 8'h83); cyc(2);
    chk("R11 range x100", range_sel, 3'b100);
    chk("R11 trim -32", trim, 6'h20);
    wr(2'd3, 8'h00); cyc(2);
    chk("R11 range off", range_sel, 3'b000);
  endtask

  task automatic t_readback();
    logic [7:0] d;
    wr(2'd0, 8'hFF);
    rd(2'd0, d); chk("R12 ctrl unimplemented bits zero", d, 8'h1F);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFF);
    rd(2'd1, d); chk("R12 route width", d, 8'h3F);
    wr(2'd1, 8'h37);
    rd(2'd1, d); chk("R12 route readback", d, 8'h37);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rising();
    t_sticky();
    t_falling();
    t_gate();
    t_disabled();
    t_pulse_trig();
    t_discharge();
    t_cmp();
    t_current();
    t_readback();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule